// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Collector

This block gathers 48 single-cycle event pulses into two 24-bit pending banks and drives one active-high, level-sensitive interrupt request. Every bank has its own disable register, in which a 1 blocks the matching source. An event sets its pending bit. Software clears a pending bit by writing a 1 to it, and writing a 0 leaves the bit as it is. The request stays high while either bank holds a pending bit whose disable bit is 0.

Software reaches the four registers through a small synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address. Several bit positions have no source. These read as zero and ignore both events and writes. Bank 0 bit 0 carries the conversion-complete event and bank 1 bit 0 carries the once-per-second tick. The interrupt controller has no notion of priority. Software decides what to service.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Register addresses are: 0 is bank 0 pending, 1 is bank 0 disable, 3 is bank 1 pending, 4 is bank 1 disable. Any other address reads 0, and a write to it changes no register.
- R2: A 1 on evtIn[i] in a cycle sets pending bit (i mod 24) of bank (i / 24) at that clock edge.
- R3: Writing the pending register of a bank clears each bit written as 1 and keeps each bit written as 0.
- R4: If an event and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: irqOut is 1 exactly when some bank has a pending bit that is 1 and whose disable bit is 0. A disable bit of 1 blocks its source.
- R6: After reset all pending bits are 0, both disable registers hold 1 on every implemented bit, and irqOut is 0.
- R7: Bank 0 bits 5, 17, 18 and 20 and bank 1 bits 2 and 16 are not implemented. They always read 0 in both the pending and the disable register, and events and writes to them have no effect.
- R8: A write to a disable register replaces its implemented bits with the written data. A source that is disabled still records its pending bit, and software can read it.
- R9: irqOut is a level. Once raised, it stays high over idle cycles until the pending bit is cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 48 | Event pulses, one per source |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe for the register at regAddr |
| regWrData | input | 24 | Write data |
| regRdData | output | 24 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Active-high level interrupt request |

## Verification
The hardest case to reach is an event and a write-one clear landing on the same pending bit at the same clock edge. The bench first clears the bit and confirms that it reads zero. It then drives the event pulse and the clear write on the same falling edge, so both are seen at one rising edge, and reads the bit back. A second hard case is a source that is disabled. Its bit must be recorded while the interrupt request stays low. The bench fires events with every source disabled, reads the pending banks, and only afterwards enables bits one at a time to watch the request follow.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int BANK_W    = 24;
  localparam int NUM_BANKS = 2;
  localparam int ADDR_W    = 3;
  localparam int REGS_PER_BANK = 3;   // pending, disable, one hole
  localparam int EVT_W     = BANK_W * NUM_BANKS;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] clrPend;   // write-one-clear on the pending register
    logic [NUM_BANKS-1:0] ldDis;     // load the disable register
    logic [NUM_BANKS-1:0] rdPend;    // select the pending register for read
    logic [NUM_BANKS-1:0] rdDis;     // select the disable register for read
  } ctlStrobe_t;

  // Implemented bits for each bank (1 = bit has a source)
  function automatic logic [BANK_W-1:0] implBits(input int bank);
    logic [BANK_W-1:0] holes;
    holes = '0;
    if (bank == 0) begin
      holes[5]  = 1'b1;
      holes[17] = 1'b1;
      holes[18] = 1'b1;
      holes[20] = 1'b1;
    end else begin
      holes[2]  = 1'b1;
      holes[16] = 1'b1;
    end
    return ~holes;
  endfunction

  function automatic logic [ADDR_W-1:0] pendAddr(input int bank);
    return ADDR_W'(bank * REGS_PER_BANK);
  endfunction

  function automatic logic [ADDR_W-1:0] disAddr(input int bank);
    return ADDR_W'(bank * REGS_PER_BANK + 1);
  endfunction

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctlStrobe_t        strobe
);

  always_comb begin
    strobe = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      strobe.rdPend[b]  = (regAddr == pendAddr(b));
      strobe.rdDis[b]   = (regAddr == disAddr(b));
      strobe.clrPend[b] = regWrEn && (regAddr == pendAddr(b));
      strobe.ldDis[b]   = regWrEn && (regAddr == disAddr(b));
    end
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [EVT_W-1:0]            evtIn,
  input  ctlStrobe_t                  strobe,
  input  logic [BANK_W-1:0]           regWrData,
  output logic [BANK_W-1:0]           regRdData,
  output logic [EVT_W-1:0]            pendFlat,
  output logic [EVT_W-1:0]            disFlat,
  output logic                        irqOut
);

  logic [NUM_BANKS-1:0][BANK_W-1:0] pendQ;
  logic [NUM_BANKS-1:0][BANK_W-1:0] disQ;
  logic [NUM_BANKS-1:0]             bankLive;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] IMPL = implBits(b);
    logic [BANK_W-1:0] evtBank;
    logic [BANK_W-1:0] clrBits;

    assign evtBank = evtIn[b*BANK_W +: BANK_W];
    assign clrBits = strobe.clrPend[b] ? regWrData : '0;

    // event wins over a simultaneous clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[b] <= '0;
      else       pendQ[b] <= ((pendQ[b] & ~clrBits) | evtBank) & IMPL;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               disQ[b] <= IMPL;
      else if (strobe.ldDis[b]) disQ[b] <= regWrData & IMPL;
    end

    assign bankLive[b] = |(pendQ[b] & ~disQ[b]);
    assign pendFlat[b*BANK_W +: BANK_W] = pendQ[b];
    assign disFlat[b*BANK_W +: BANK_W]  = disQ[b];
  end

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.rdPend[b]) regRdData = regRdData | pendQ[b];
      if (strobe.rdDis[b])  regRdData = regRdData | disQ[b];
    end
  end

  assign irqOut = |bankLive;

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_W-1:0]     evtIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [BANK_W-1:0]    regWrData,
  output logic [BANK_W-1:0]    regRdData,
  output logic                 irqOut
);

  ctlStrobe_t          strobe;
  logic [EVT_W-1:0]    pendFlat;
  logic [EVT_W-1:0]    disFlat;

  irqc_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  irqc_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pendFlat  (pendFlat),
    .disFlat   (disFlat),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [EVT_W-1:0]     evtIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [BANK_W-1:0]    regWrData,
  input  logic                 irqOut,
  input  logic [EVT_W-1:0]     pendFlat,
  input  logic [EVT_W-1:0]     disFlat
);

  localparam logic [BANK_W-1:0] IMPL0 = implBits(0);
  localparam logic [BANK_W-1:0] IMPL1 = implBits(1);

  // R2: an event pulse is recorded on the next edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendFlat & {$past(evtIn[EVT_W-1:BANK_W]) & IMPL1, $past(evtIn[BANK_W-1:0]) & IMPL0})
             == {$past(evtIn[EVT_W-1:BANK_W]) & IMPL1, $past(evtIn[BANK_W-1:0]) & IMPL0}));

  // R3: write-one clear of bank 0 removes bits that saw no event
  a_r3_clear_bank0: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0) |=>
      ((pendFlat[BANK_W-1:0] & $past(regWrData) & ~$past(evtIn[BANK_W-1:0])) == '0));

  // R7: holes never hold a 1
  a_r7_holes_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((pendFlat[BANK_W-1:0] | disFlat[BANK_W-1:0]) & ~IMPL0) == '0 &&
    ((pendFlat[EVT_W-1:BANK_W] | disFlat[EVT_W-1:BANK_W]) & ~IMPL1) == '0);

  // R8: disable register of bank 0 only changes on its own write
  a_r8_dis_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 3'd1) |=> $stable(disFlat[BANK_W-1:0]));

  // R1: a write to address 1 loads bank 0 disable bits
  a_r1_dis_load: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd1) |=> (disFlat[BANK_W-1:0] == ($past(regWrData) & IMPL0)));

  // R5: all sources disabled keeps the request low
  a_r5_all_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (disFlat[BANK_W-1:0] == IMPL0 && disFlat[EVT_W-1:BANK_W] == IMPL1) |-> !irqOut);

endmodule

bind irq_bank_ctrl irqc_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .irqOut    (irqOut),
  .pendFlat  (pendFlat),
  .disFlat   (disFlat)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] evtIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [23:0] regWrData = '0;
  logic [23:0] regRdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;

  localparam logic [23:0] ALL0 = 24'hE9FFDF;
  localparam logic [23:0] ALL1 = 24'hFEFFFB;

  always #10 clk = ~clk;

  irq_bank_ctrl dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [23:0] exp);
    logic [23:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evtIn[idx] = 1'b1;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic t_reset();
    rdChk("R6 pend0", 3'd0, 24'h0);
    rdChk("R6 pend1", 3'd3, 24'h0);
    rdChk("R6 dis0", 3'd1, ALL0);
    rdChk("R6 dis1", 3'd4, ALL1);
    chk("R6 irq", {23'd0, irqOut}, 24'd0);
  endtask

  task automatic t_events();
    pulse(0); pulse(24); pulse(47);
    rdChk("R2 pend0", 3'd0, 24'h000001);
    rdChk("R2 pend1", 3'd3, 24'h800001);
    chk("R8 latched while disabled irq", {23'd0, irqOut}, 24'd0);
  endtask

  task automatic t_holes();
    pulse(5); pulse(17); pulse(26); pulse(40);
    rdChk("R7 pend0 holes", 3'd0, 24'h000001);
    rdChk("R7 pend1 holes", 3'd3, 24'h800001);
    wr(3'd1, 24'hFFFFFF);
    rdChk("R7 dis0 holes", 3'd1, ALL0);
    wr(3'd4, 24'h000000);
    rdChk("R8 dis1 replaced", 3'd4, 24'h000000);
    chk("R5 irq with bank1 enabled", {23'd0, irqOut}, 24'd1);
    wr(3'd4, 24'hFFFFFF);
    rdChk("R7 dis1 holes", 3'd4, ALL1);
  endtask

  task automatic t_enable();
    wr(3'd1, ALL0 & ~24'h1);
    chk("R5 irq bank0 bit0", {23'd0, irqOut}, 24'd1);
    repeat (3) @(negedge clk);
    chk("R9 irq holds", {23'd0, irqOut}, 24'd1);
    wr(3'd1, 24'hFFFFFF);
    chk("R5 irq after disable", {23'd0, irqOut}, 24'd0);
    wr(3'd4, 24'h7FFFFF);
    chk("R5 irq bank1 bit23", {23'd0, irqOut}, 24'd1);
    wr(3'd4, 24'hFFFFFF);
    chk("R5 irq off", {23'd0, irqOut}, 24'd0);
  endtask

  task automatic t_clear();
    wr(3'd3, 24'h000000);
    rdChk("R3 zero write keeps", 3'd3, 24'h800001);
    wr(3'd3, 24'h800000);
    rdChk("R3 clear bit23", 3'd3, 24'h000001);
    wr(3'd4, 24'hFFFFFE);
    chk("R9 irq raised", {23'd0, irqOut}, 24'd1);
    wr(3'd3, 24'h000001);
    rdChk("R3 clear bit0", 3'd3, 24'h000000);
    chk("R9 irq drops after clear", {23'd0, irqOut}, 24'd0);
    wr(3'd4, 24'hFFFFFF);
  endtask

  task automatic t_collide();
    wr(3'd0, 24'h000001);
    rdChk("R3 bank0 cleared", 3'd0, 24'h000000);
    @(negedge clk);
    evtIn[0] = 1'b1;
    regAddr = 3'd0; regWrData = 24'h000001; regWrEn = 1'b1;
    @(negedge clk);
    evtIn = '0; regWrEn = 1'b0; regWrData = '0;
    rdChk("R4 event beats clear", 3'd0, 24'h000001);
  endtask

  task automatic t_holesAddr();
    wr(3'd2, 24'hFFFFFF);
    wr(3'd5, 24'hFFFFFF);
    wr(3'd7, 24'hFFFFFF);
    rdChk("R1 pend0 untouched", 3'd0, 24'h000001);
    rdChk("R1 dis0 untouched", 3'd1, ALL0);
    rdChk("R1 dis1 untouched", 3'd4, ALL1);
    rdChk("R1 addr2", 3'd2, 24'h0);
    rdChk("R1 addr5", 3'd5, 24'h0);
    rdChk("R1 addr6", 3'd6, 24'h0);
    rdChk("R1 addr7", 3'd7, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_holes();
    t_enable();
    t_clear();
    t_collide();
    t_holesAddr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 24'd1, 24'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule